// File: doc/BRIEF.md
# Dual-Port Byte RAM with Collision Busy and Write Inhibit

This block is a 2048-entry, byte-wide memory with two independent access ports, left and right. Each port has an active-low select, a read/write strobe (low means write), an active-low output enable, an address and a write byte. It returns a read byte and a flag that says whether that byte is being driven. Either port can read or write any location at any time. Writes take effect on the clock edge. Reads are registered and have one cycle of latency.

A parameter chooses between two roles. As a master, the block has an arbiter that watches for both ports selecting the same address. When that happens it raises busy on exactly one port and suppresses that port's write. As a slave, the block has no arbiter. It takes the busy lines from outside and uses them only to block writes. Several slaves can then follow one master's decision, so a wider word is never split between the two sides.

Top module: `dpram_busy`

## Requirements
- R1: After reset both read-valid flags are 0, both read bytes are 0, and both busy outputs are 1 (not busy).
- R2: With select low, strobe low and busy high on the same port, the write byte is stored at the address on the next clock edge.
- R3: With select low, strobe high and output enable low, the next cycle shows the stored byte on that port's read byte, and its read-valid flag is 1.
- R4: With select high, the port writes nothing, and in the next cycle its read-valid flag is 0.
- R5: With output enable high, in the next cycle the read-valid flag is 0 and the read byte is 0, even when the port is selected for a read.
- R6: The two ports work independently on different addresses in the same cycle. A read issued in the same cycle as the other port's write returns the old byte. A read issued one cycle later returns the new byte.
- R7: In master mode, busy (active low) goes low on a port only while both ports are selected at equal addresses, and never on both ports at once.
- R8: In master mode, when a collision starts, a port that held the same address selected in the previous cycle wins and the newcomer gets busy. When both arrive together, or both were already holding it, the right port gets busy.
- R9: A write attempted on a port while its busy is low leaves the stored byte unchanged.
- R10: In slave mode, the busy inputs (active low) block writes on their own port only, and both busy outputs stay 1.
- R11: In slave mode, if both ports write the same address in one cycle with neither port busy, the left port's byte is stored.
- R12: In master mode, the busy decision stays the same on every cycle while the collision continues at an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left read/write strobe, low = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write byte |
| l_rdata | output | DATA_W | Left read byte, 0 when not driven |
| l_rdata_oe | output | 1 | Left read byte is being driven |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right read/write strobe, low = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write byte |
| r_rdata | output | DATA_W | Right read byte, 0 when not driven |
| r_rdata_oe | output | 1 | Right read byte is being driven |
| l_busy_in_n | input | 1 | Left external busy, active low (slave mode only) |
| r_busy_in_n | input | 1 | Right external busy, active low (slave mode only) |
| l_busy_n | output | 1 | Left busy from arbiter, active low (1 in slave mode) |
| r_busy_n | output | 1 | Right busy from arbiter, active low (1 in slave mode) |

## Verification
The bench builds two copies with the default 11-bit address and 8-bit data. One copy is a master (IS_MASTER=1) and one is a slave (IS_MASTER=0), and both receive the same port stimulus. The master copy covers the arbiter cases: left holding first, right holding first, both arriving together, and the decision held across a continuing collision. The slave copy reaches the cases the arbiter would otherwise hide: externally forced inhibit, two writes to the same address in one cycle, and a read that overlaps the other port's write.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // Winner of a fresh collision: a port that already held the address wins;
  // otherwise the left side has priority.
  function automatic side_e first_owner(input logic held_l, input logic held_r);
    return (held_r && !held_l) ? SIDE_R : SIDE_L;
  endfunction

  function automatic logic write_strobe(input logic cs_n, input logic we_n,
                                        input logic busy_n);
    return !cs_n && !we_n && busy_n;
  endfunction

  function automatic logic read_strobe(input logic cs_n, input logic we_n);
    return !cs_n && we_n;
  endfunction

endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
  import dpr_pkg::*;
(
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic busy_n,
  output logic wr_fire,
  output logic rd_fire,
  output logic drive
);

  always_comb begin
    wr_fire = write_strobe(cs_n, we_n, busy_n);
    rd_fire = read_strobe(cs_n, we_n);
    drive   = rd_fire && !oe_n;
  end

endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              clash
);

  logic              l_sel_q, r_sel_q, clash_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  side_e             owner_q, owner_now;
  logic              held_l, held_r, clash_cont;

  always_comb begin
    clash      = l_sel && r_sel && (l_addr == r_addr);
    held_l     = l_sel && l_sel_q && (l_addr == l_addr_q);
    held_r     = r_sel && r_sel_q && (r_addr == r_addr_q);
    clash_cont = clash && clash_q && (l_addr == l_addr_q);
    owner_now  = clash_cont ? owner_q : first_owner(held_l, held_r);
    l_busy_n   = !(clash && owner_now == SIDE_R);
    r_busy_n   = !(clash && owner_now == SIDE_L);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_sel_q  <= 1'b0;
      r_sel_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      clash_q  <= 1'b0;
      owner_q  <= SIDE_L;
    end else begin
      l_sel_q  <= l_sel;
      r_sel_q  <= r_sel;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      clash_q  <= clash;
      if (clash) owner_q <= owner_now;
    end
  end

endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_we,
  input  logic              l_re,
  input  logic              l_drive,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdata_oe,
  input  logic              r_we,
  input  logic              r_re,
  input  logic              r_drive,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdata_oe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] l_q, r_q;
  logic              l_oe_q, r_oe_q;

  // Right first, left last: left wins a same-address double write.
  always_ff @(posedge clk) begin
    if (r_we) cells[r_addr] <= r_wdata;
    if (l_we) cells[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q    <= '0;
      r_q    <= '0;
      l_oe_q <= 1'b0;
      r_oe_q <= 1'b0;
    end else begin
      if (l_re) l_q <= cells[l_addr];
      if (r_re) r_q <= cells[r_addr];
      l_oe_q <= l_drive;
      r_oe_q <= r_drive;
    end
  end

  assign l_rdata    = l_oe_q ? l_q : '0;
  assign r_rdata    = r_oe_q ? r_q : '0;
  assign l_rdata_oe = l_oe_q;
  assign r_rdata_oe = r_oe_q;

endmodule

// File: rtl/dpram_busy.sv
module dpram_busy #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdata_oe,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdata_oe,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n
);

  logic l_busy_eff_n, r_busy_eff_n;
  logic l_wr_fire, r_wr_fire, l_rd_fire, r_rd_fire, l_drive, r_drive;

  generate
    if (IS_MASTER) begin : g_master
      logic arb_l_n, arb_r_n, arb_clash;
      logic unused_busy_in;
      dpr_arbiter #(.ADDR_W(ADDR_W)) arb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_sel    (!l_cs_n),
        .r_sel    (!r_cs_n),
        .l_addr   (l_addr),
        .r_addr   (r_addr),
        .l_busy_n (arb_l_n),
        .r_busy_n (arb_r_n),
        .clash    (arb_clash)
      );
      assign unused_busy_in = ^{l_busy_in_n, r_busy_in_n, arb_clash};
      assign l_busy_eff_n   = arb_l_n;
      assign r_busy_eff_n   = arb_r_n;
      assign l_busy_n       = arb_l_n;
      assign r_busy_n       = arb_r_n;
    end else begin : g_slave
      assign l_busy_eff_n = l_busy_in_n;
      assign r_busy_eff_n = r_busy_in_n;
      assign l_busy_n     = 1'b1;
      assign r_busy_n     = 1'b1;
    end
  endgenerate

  dpr_port_ctrl l_ctrl_i (
    .cs_n (l_cs_n), .we_n (l_we_n), .oe_n (l_oe_n), .busy_n (l_busy_eff_n),
    .wr_fire (l_wr_fire), .rd_fire (l_rd_fire), .drive (l_drive)
  );

  dpr_port_ctrl r_ctrl_i (
    .cs_n (r_cs_n), .we_n (r_we_n), .oe_n (r_oe_n), .busy_n (r_busy_eff_n),
    .wr_fire (r_wr_fire), .rd_fire (r_rd_fire), .drive (r_drive)
  );

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .l_we       (l_wr_fire),
    .l_re       (l_rd_fire),
    .l_drive    (l_drive),
    .l_addr     (l_addr),
    .l_wdata    (l_wdata),
    .l_rdata    (l_rdata),
    .l_rdata_oe (l_rdata_oe),
    .r_we       (r_wr_fire),
    .r_re       (r_rd_fire),
    .r_drive    (r_drive),
    .r_addr     (r_addr),
    .r_wdata    (r_wdata),
    .r_rdata    (r_rdata),
    .r_rdata_oe (r_rdata_oe)
  );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int ADDR_W    = 11,
  parameter bit IS_MASTER = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_cs_n,
  input logic              l_we_n,
  input logic              l_oe_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_cs_n,
  input logic              r_we_n,
  input logic              r_oe_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_busy_eff_n,
  input logic              r_busy_eff_n,
  input logic              l_wr_fire,
  input logic              r_wr_fire,
  input logic              l_rdata_oe,
  input logic              r_rdata_oe
);

  logic both_same;
  assign both_same = !l_cs_n && !r_cs_n && (l_addr == r_addr);

  p_read_valid_l_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && l_we_n && !l_oe_n) |=> l_rdata_oe);
  p_read_valid_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_cs_n && r_we_n && !r_oe_n) |=> r_rdata_oe);
  p_idle_quiet_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
    l_cs_n |=> !l_rdata_oe);
  p_oe_release_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
    r_oe_n |=> !r_rdata_oe);
  p_inhibit_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
    l_wr_fire |-> l_busy_eff_n);
  p_inhibit_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
    r_wr_fire |-> r_busy_eff_n);

  generate
    if (IS_MASTER) begin : g_master_chk
      p_busy_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));
      p_busy_needs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n || !r_busy_n) |-> both_same);
      p_decision_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!l_busy_n) && both_same && $stable(l_addr)) |-> !l_busy_n);
    end else begin : g_slave_chk
      p_slave_busy_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        both_same |-> (l_busy_n && r_busy_n));
    end
  endgenerate

endmodule

bind dpram_busy dpr_checker #(.ADDR_W(ADDR_W), .IS_MASTER(IS_MASTER)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .l_cs_n       (l_cs_n),
  .l_we_n       (l_we_n),
  .l_oe_n       (l_oe_n),
  .l_addr       (l_addr),
  .r_cs_n       (r_cs_n),
  .r_we_n       (r_we_n),
  .r_oe_n       (r_oe_n),
  .r_addr       (r_addr),
  .l_busy_n     (l_busy_n),
  .r_busy_n     (r_busy_n),
  .l_busy_eff_n (l_busy_eff_n),
  .r_busy_eff_n (r_busy_eff_n),
  .l_wr_fire    (l_wr_fire),
  .r_wr_fire    (r_wr_fire),
  .l_rdata_oe   (l_rdata_oe),
  .r_rdata_oe   (r_rdata_oe)
);

// File: tb/dpram_busy_tb_top.sv
module dpram_busy_tb_top;

  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          l_cs_n, l_we_n, l_oe_n, r_cs_n, r_we_n, r_oe_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata;
  logic          l_bin_n, r_bin_n;

  logic [DW-1:0] m_l_rdata, m_r_rdata, s_l_rdata, s_r_rdata;
  logic          m_l_oe, m_r_oe, s_l_oe, s_r_oe;
  logic          m_l_busy_n, m_r_busy_n, s_l_busy_n, s_r_busy_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dpram_busy #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(m_l_rdata), .l_rdata_oe(m_l_oe),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(m_r_rdata), .r_rdata_oe(m_r_oe),
    .l_busy_in_n(l_bin_n), .r_busy_in_n(r_bin_n),
    .l_busy_n(m_l_busy_n), .r_busy_n(m_r_busy_n)
  );

  dpram_busy #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b0)) dut_slv_i (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(s_l_rdata), .l_rdata_oe(s_l_oe),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(s_r_rdata), .r_rdata_oe(s_r_oe),
    .l_busy_in_n(l_bin_n), .r_busy_in_n(r_bin_n),
    .l_busy_n(s_l_busy_n), .r_busy_n(s_r_busy_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // cs, we, oe are active low as on the ports
  task automatic set_l(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_cs_n = cs; l_we_n = we; l_oe_n = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_cs_n = cs; r_we_n = we; r_oe_n = oe; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    set_l(1, 1, 1, '0, '0);
    set_r(1, 1, 1, '0, '0);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1 m_l_oe", m_l_oe, 0);
    check("R1 m_r_oe", m_r_oe, 0);
    check("R1 m_l_rdata", m_l_rdata, 0);
    check("R1 m_l_busy", m_l_busy_n, 1);
    check("R1 m_r_busy", m_r_busy_n, 1);
  endtask

  task automatic t_write_read();
    set_l(0, 0, 1, 11'd10, 8'h3C); tick();
    set_l(0, 1, 0, 11'd10, 8'h00); tick();
    check("R2 stored byte", m_l_rdata, 8'h3C);
    check("R3 read valid", m_l_oe, 1);
  endtask

  task automatic t_oe_release();
    set_l(0, 1, 1, 11'd10, 8'h00); tick();
    check("R5 valid low", m_l_oe, 0);
    check("R5 byte zero", m_l_rdata, 0);
  endtask

  task automatic t_deselect();
    set_l(1, 0, 0, 11'd10, 8'hFF); tick();
    check("R4 valid low", m_l_oe, 0);
    set_l(0, 1, 0, 11'd10, 8'h00); tick();
    check("R4 no write", m_l_rdata, 8'h3C);
  endtask

  task automatic t_parallel();
    set_l(0, 0, 1, 11'd40, 8'hA1); set_r(0, 0, 1, 11'd41, 8'hB2); #1;
    check("R7 no busy on distinct l", m_l_busy_n, 1);
    check("R7 no busy on distinct r", m_r_busy_n, 1);
    tick();
    set_l(0, 1, 0, 11'd41, 8'h00); set_r(0, 1, 0, 11'd40, 8'h00); tick();
    check("R6 left sees right write", m_l_rdata, 8'hB2);
    check("R6 right sees left write", m_r_rdata, 8'hA1);
  endtask

  task automatic t_left_first();
    idle(); set_l(0, 0, 1, 11'd50, 8'h77); tick();
    set_l(0, 1, 0, 11'd50, 8'h00); set_r(0, 1, 0, 11'd51, 8'h00); tick();
    set_r(0, 0, 1, 11'd50, 8'hEE); #1;
    check("R8 newcomer right busy", m_r_busy_n, 0);
    check("R7 holder left free", m_l_busy_n, 1);
    tick();
    idle(); set_r(0, 1, 0, 11'd50, 8'h00); tick();
    check("R9 inhibited right write", m_r_rdata, 8'h77);
  endtask

  task automatic t_right_first();
    idle(); set_l(0, 0, 1, 11'd60, 8'h12); tick();
    set_l(0, 1, 0, 11'd61, 8'h00); set_r(0, 1, 0, 11'd60, 8'h00); tick();
    set_l(0, 0, 1, 11'd60, 8'h99); #1;
    check("R8 newcomer left busy", m_l_busy_n, 0);
    check("R8 holder right free", m_r_busy_n, 1);
    tick(); #1;
    check("R12 left still busy", m_l_busy_n, 0);
    check("R12 right still free", m_r_busy_n, 1);
    tick();
    idle(); set_l(0, 1, 0, 11'd60, 8'h00); tick();
    check("R9 inhibited left write", m_l_rdata, 8'h12);
  endtask

  task automatic t_tie();
    idle(); tick();
    set_l(0, 0, 1, 11'd70, 8'hAA); set_r(0, 0, 1, 11'd70, 8'hBB); #1;
    check("R8 tie right busy", m_r_busy_n, 0);
    check("R8 tie left free", m_l_busy_n, 1);
    tick();
    idle(); set_r(0, 1, 0, 11'd70, 8'h00); tick();
    check("R9 tie keeps left byte", m_r_rdata, 8'hAA);
  endtask

  task automatic t_slave_inhibit();
    idle(); set_l(0, 0, 1, 11'd80, 8'h10); tick();
    l_bin_n = 0;
    set_l(0, 0, 1, 11'd80, 8'h20); set_r(0, 0, 1, 11'd81, 8'h21); tick();
    l_bin_n = 1;
    set_l(0, 1, 0, 11'd80, 8'h00); set_r(0, 1, 0, 11'd81, 8'h00); tick();
    check("R10 left write blocked", s_l_rdata, 8'h10);
    check("R10 right write unaffected", s_r_rdata, 8'h21);
  endtask

  task automatic t_slave_double();
    idle(); set_l(0, 0, 1, 11'd90, 8'h31); set_r(0, 0, 1, 11'd90, 8'h32); #1;
    check("R10 slave busy out l", s_l_busy_n, 1);
    check("R10 slave busy out r", s_r_busy_n, 1);
    tick();
    idle(); set_r(0, 1, 0, 11'd90, 8'h00); tick();
    check("R11 left byte kept", s_r_rdata, 8'h31);
  endtask

  task automatic t_slave_overlap();
    idle(); set_l(0, 0, 1, 11'd30, 8'h01); tick();
    set_l(0, 1, 0, 11'd30, 8'h00); set_r(0, 0, 1, 11'd30, 8'h02); tick();
    check("R6 same-cycle old byte", s_l_rdata, 8'h01);
    set_r(1, 1, 1, 11'd0, 8'h00); tick();
    check("R6 next-cycle new byte", s_l_rdata, 8'h02);
  endtask

  initial begin
    idle(); l_bin_n = 1; r_bin_n = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_oe_release();
    t_deselect();
    t_parallel();
    t_left_first();
    t_right_first();
    t_tie();
    t_slave_inhibit();
    t_slave_double();
    t_slave_overlap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule